// File: doc/BRIEF.md
# Sample-Phase Tuning Sequencer

This block calibrates the receive sampling phase of a high-speed card host interface. A start pulse makes it read the clock-select register. It then sweeps the 3-bit sample-phase field in bits [2:0] of that register through all eight positions. At each position it runs one tuning trial and records pass or fail in an 8-bit candidate mask. When the sweep is over, a window search picks the final phase and writes it back into the register. No other bit of the register changes.

The block only drives a register-style port: one read of the clock-select register, and writes to that register and to the data timeout register. Issuing the tuning command and comparing the returned data are done elsewhere. They appear here as a trial request answered by a done pulse carrying a pass level. The search reads the mask as a ring and tries three rules in turn. The first accepts five passing phases around the candidate, the second three, and the third any single pass. Within a rule, the lowest candidate index wins.

Top module: `phase_tune_seq`

## Requirements
- R1: A start pulse in idle causes exactly one read of the clock-select address. Read data is taken in the cycle after `reg_rd_en`. With starting phase s taken from bits [2:0], exactly eight trials run, at phases s+1, s+2, …, s+7, s (mod 8), in that order. The phase of each trial is written into bits [2:0] before that trial's request.
- R2: Every write to the clock-select address keeps bits [REG_W-1:3] equal to the value read at start.
- R3: Between the end of the previous trial and each trial request, the timeout address is written with all ones.
- R4: A passing trial at phase p sets mask bit p. If for some i the phases i-1 through i+3 (mod 8) all passed, the lowest such i is written back as the final phase.
- R5: If no five-wide match exists, the final phase is the lowest i for which phases i, i+1 and i+2 (mod 8) all passed.
- R6: If neither wider rule matches, the final phase is the lowest i for which phase i+1 (mod 8) passed.
- R7: If all eight trials fail, `error` is high together with `done` and no write-back happens, so the field is left at the starting phase. `error` is never high without `done`.
- R8: The search tests one candidate per cycle in the order rule 1 (i=0..7), rule 2, rule 3. Let the final `trial_done` be sampled at edge T and let the winning candidate be the k-th tested. Then `done` is high for exactly one cycle, the one beginning at edge T+k+1. With no pass at all it is the cycle beginning at edge T+24. `error` is low on success. After reset all outputs are idle.
- R9: A start pulse while a tuning run is in progress is ignored. There is no second read, no extra trial and no extra `done`.
- R10: `trial_req` is a one-cycle pulse. No new request is issued until the previous one has been answered by `trial_done`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start | input | 1 | One-cycle pulse that begins a tuning run |
| done | output | 1 | One-cycle pulse when the run ends |
| error | output | 1 | High with `done` when no phase passed |
| reg_rd_en | output | 1 | Read strobe; data expected on `reg_rdata` the next cycle |
| reg_wr_en | output | 1 | Write strobe |
| reg_addr | output | ADDR_W | Register address for the read or write |
| reg_wdata | output | REG_W | Write data |
| reg_rdata | input | REG_W | Read data of the clock-select register |
| trial_req | output | 1 | One-cycle request to run a tuning trial |
| trial_done | input | 1 | One-cycle answer to a trial request |
| trial_pass | input | 1 | Trial result, valid with `trial_done` |

## Verification
The bench has a behavioural register model and a trial responder with a different latency in each run. At the negative edge after each trial request it checks that the register model holds the expected phase and a fresh all-ones timeout value. It checks every clock-select write as it happens. After the final answer, the bench works out from the pass pattern which candidate wins and in which test k it is found. It then counts edges and requires `done` in exactly the cycle starting at edge T+k+1 (T+24 when nothing passed), and low on every other sampled cycle. The final register value and the write count are checked after `done`.

// File: rtl/phase_tune_pkg.sv
package phase_tune_pkg;

  localparam int PH_W = 3;
  localparam int N_PH = 1 << PH_W;

  typedef enum logic [3:0] {
    S_IDLE,
    S_RD,
    S_CAP,
    S_TMO,
    S_STEP,
    S_REQ,
    S_WAIT,
    S_SRCH,
    S_WB,
    S_FIN
  } seq_state_t;

  typedef enum logic [1:0] {
    T_WIDE = 2'd0,
    T_MID  = 2'd1,
    T_ANY  = 2'd2
  } tier_t;

  // Bits of the rotated mask that must all be set for each rule
  function automatic logic [N_PH-1:0] tier_pattern(input tier_t t);
    case (t)
      T_WIDE:  return 8'hC7;
      T_MID:   return 8'h83;
      default: return 8'h01;
    endcase
  endfunction

endpackage

// File: rtl/phase_tune_mask.sv
module phase_tune_mask #(
  parameter int N  = 8,
  parameter int IW = 3
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          clr,
  input  logic          set_en,
  input  logic [IW-1:0] set_idx,
  input  logic          set_val,
  output logic [N-1:0]  mask_o
);

  logic [N-1:0] mask_q;
  logic [N-1:0] mask_d;
  logic         mask_en;

  always_comb begin
    mask_d  = mask_q;
    mask_en = clr | set_en;
    if (clr) begin
      mask_d = '0;
    end else if (set_en) begin
      mask_d[set_idx] = set_val;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mask_q <= '0;
    end else if (mask_en) begin
      mask_q <= mask_d;
    end
  end

  assign mask_o = mask_q;

endmodule

// File: rtl/phase_tune_search.sv
module phase_tune_search
  import phase_tune_pkg::*;
#(
  parameter int N  = 8,
  parameter int IW = 3
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          go,
  input  logic [N-1:0]  mask,
  output logic          hit_o,
  output logic          miss_o,
  output logic [IW-1:0] phase_o
);

  localparam logic [IW-1:0] IDX_LAST = IW'(N - 1);

  logic          active_q, active_d;
  tier_t         tier_q, tier_d;
  logic [IW-1:0] idx_q, idx_d;
  logic          step_en;

  logic [IW:0]    shamt;
  logic [2*N-1:0] ring;
  logic [2*N-1:0] ring_sh;
  logic [N-1:0]   rot;
  logic [N-1:0]   pat;
  logic           match;
  logic           last_idx;

  // Rotate right by idx+1 through a doubled copy of the mask
  assign shamt   = {1'b0, idx_q} + {{IW{1'b0}}, 1'b1};
  assign ring    = {mask, mask};
  assign ring_sh = ring >> shamt;
  assign rot     = ring_sh[N-1:0];
  assign pat     = tier_pattern(tier_q);
  assign match   = ((rot & pat) == pat);
  assign last_idx = (idx_q == IDX_LAST);

  assign hit_o   = active_q & match;
  assign miss_o  = active_q & ~match & last_idx & (tier_q == T_ANY);
  assign phase_o = idx_q;

  always_comb begin
    active_d = active_q;
    tier_d   = tier_q;
    idx_d    = idx_q;
    step_en  = go | active_q;
    if (go) begin
      active_d = 1'b1;
      tier_d   = T_WIDE;
      idx_d    = '0;
    end else if (active_q) begin
      if (hit_o || miss_o) begin
        active_d = 1'b0;
      end else if (last_idx) begin
        idx_d = '0;
        case (tier_q)
          T_WIDE:  tier_d = T_MID;
          T_MID:   tier_d = T_ANY;
          default: tier_d = T_ANY;
        endcase
      end else begin
        idx_d = idx_q + {{(IW-1){1'b0}}, 1'b1};
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      active_q <= 1'b0;
      tier_q   <= T_WIDE;
      idx_q    <= '0;
    end else if (step_en) begin
      active_q <= active_d;
      tier_q   <= tier_d;
      idx_q    <= idx_d;
    end
  end

endmodule

// File: rtl/phase_tune_seq.sv
module phase_tune_seq
  import phase_tune_pkg::*;
#(
  parameter int REG_W       = 32,
  parameter int ADDR_W      = 4,
  parameter int CLKSEL_ADDR = 0,
  parameter int TMO_ADDR    = 1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start,
  output logic              done,
  output logic              error,
  output logic              reg_rd_en,
  output logic              reg_wr_en,
  output logic [ADDR_W-1:0] reg_addr,
  output logic [REG_W-1:0]  reg_wdata,
  input  logic [REG_W-1:0]  reg_rdata,
  output logic              trial_req,
  input  logic              trial_done,
  input  logic              trial_pass
);

  localparam int UP_W = REG_W - PH_W;
  localparam logic [ADDR_W-1:0] A_CLKSEL = ADDR_W'(CLKSEL_ADDR);
  localparam logic [ADDR_W-1:0] A_TMO    = ADDR_W'(TMO_ADDR);
  localparam logic [PH_W-1:0]   PH_ONE   = {{(PH_W-1){1'b0}}, 1'b1};

  seq_state_t      state_q, state_d;
  logic [UP_W-1:0] upper_q;
  logic [PH_W-1:0] base_q;
  logic [PH_W-1:0] cur_q, cur_d;
  logic [PH_W-1:0] sel_q;
  logic            err_q, err_d;

  logic ctx_en, cur_en, sel_en, err_en;
  logic mask_clr, mask_set, srch_go;
  logic srch_hit, srch_miss;
  logic [PH_W-1:0] srch_phase;
  logic [N_PH-1:0] cand_mask;
  logic [PH_W-1:0] step_ph;

  assign step_ph = cur_q + PH_ONE;

  phase_tune_mask #(.N(N_PH), .IW(PH_W)) u_mask (
    .clk     (clk),
    .rst_n   (rst_n),
    .clr     (mask_clr),
    .set_en  (mask_set),
    .set_idx (cur_q),
    .set_val (trial_pass),
    .mask_o  (cand_mask)
  );

  phase_tune_search #(.N(N_PH), .IW(PH_W)) u_search (
    .clk     (clk),
    .rst_n   (rst_n),
    .go      (srch_go),
    .mask    (cand_mask),
    .hit_o   (srch_hit),
    .miss_o  (srch_miss),
    .phase_o (srch_phase)
  );

  // Next state and outputs
  always_comb begin
    state_d   = state_q;
    ctx_en    = 1'b0;
    cur_en    = 1'b0;
    sel_en    = 1'b0;
    err_en    = 1'b0;
    err_d     = err_q;
    mask_clr  = 1'b0;
    mask_set  = 1'b0;
    srch_go   = 1'b0;
    reg_rd_en = 1'b0;
    reg_wr_en = 1'b0;
    reg_addr  = '0;
    reg_wdata = '0;
    trial_req = 1'b0;
    done      = 1'b0;
    error     = 1'b0;
    case (state_q)
      S_IDLE: begin
        if (start) begin
          state_d = S_RD;
          err_en  = 1'b1;
          err_d   = 1'b0;
        end
      end
      S_RD: begin
        reg_rd_en = 1'b1;
        reg_addr  = A_CLKSEL;
        state_d   = S_CAP;
      end
      S_CAP: begin
        ctx_en   = 1'b1;
        mask_clr = 1'b1;
        state_d  = S_TMO;
      end
      S_TMO: begin
        reg_wr_en = 1'b1;
        reg_addr  = A_TMO;
        reg_wdata = '1;
        state_d   = S_STEP;
      end
      S_STEP: begin
        reg_wr_en = 1'b1;
        reg_addr  = A_CLKSEL;
        reg_wdata = {upper_q, step_ph};
        cur_en    = 1'b1;
        state_d   = S_REQ;
      end
      S_REQ: begin
        trial_req = 1'b1;
        state_d   = S_WAIT;
      end
      S_WAIT: begin
        if (trial_done) begin
          mask_set = 1'b1;
          if (cur_q == base_q) begin
            srch_go = 1'b1;
            state_d = S_SRCH;
          end else begin
            state_d = S_TMO;
          end
        end
      end
      S_SRCH: begin
        if (srch_hit) begin
          sel_en  = 1'b1;
          state_d = S_WB;
        end else if (srch_miss) begin
          err_en  = 1'b1;
          err_d   = 1'b1;
          state_d = S_FIN;
        end
      end
      S_WB: begin
        reg_wr_en = 1'b1;
        reg_addr  = A_CLKSEL;
        reg_wdata = {upper_q, sel_q};
        state_d   = S_FIN;
      end
      S_FIN: begin
        done    = 1'b1;
        error   = err_q;
        state_d = S_IDLE;
      end
      default: state_d = S_IDLE;
    endcase
  end

  always_comb begin
    cur_d = ctx_en ? reg_rdata[PH_W-1:0] : step_ph;
  end

  // Registers
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= S_IDLE;
    end else begin
      state_q <= state_d;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      upper_q <= '0;
      base_q  <= '0;
    end else if (ctx_en) begin
      upper_q <= reg_rdata[REG_W-1:PH_W];
      base_q  <= reg_rdata[PH_W-1:0];
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cur_q <= '0;
    end else if (ctx_en || cur_en) begin
      cur_q <= cur_d;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sel_q <= '0;
    end else if (sel_en) begin
      sel_q <= srch_phase;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      err_q <= 1'b0;
    end else if (err_en) begin
      err_q <= err_d;
    end
  end

endmodule

// File: rtl/phase_tune_chk.sv
module phase_tune_chk #(
  parameter int REG_W       = 32,
  parameter int ADDR_W      = 4,
  parameter int CLKSEL_ADDR = 0,
  parameter int TMO_ADDR    = 1
) (
  input logic                clk,
  input logic                rst_n,
  input logic                done,
  input logic                error,
  input logic                reg_rd_en,
  input logic                reg_wr_en,
  input logic [ADDR_W-1:0]   reg_addr,
  input logic [REG_W-1:0]    reg_wdata,
  input logic [REG_W-4:0]    rd_upper,
  input logic                trial_req,
  input logic                trial_done
);

  localparam logic [ADDR_W-1:0] A_CLKSEL = ADDR_W'(CLKSEL_ADDR);
  localparam logic [ADDR_W-1:0] A_TMO    = ADDR_W'(TMO_ADDR);

  logic             pend_q;
  logic             rd_pend_q;
  logic             have_up_q;
  logic [REG_W-4:0] up_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pend_q    <= 1'b0;
      rd_pend_q <= 1'b0;
      have_up_q <= 1'b0;
      up_q      <= '0;
    end else begin
      rd_pend_q <= reg_rd_en;
      if (trial_req) pend_q <= 1'b1;
      else if (trial_done) pend_q <= 1'b0;
      if (rd_pend_q) begin
        up_q      <= rd_upper;
        have_up_q <= 1'b1;
      end
    end
  end

  assert_req_pulse_R10: assert property (@(posedge clk) disable iff (!rst_n)
    trial_req |=> !trial_req);

  assert_req_outstanding_R10: assert property (@(posedge clk) disable iff (!rst_n)
    trial_req |-> !pend_q);

  assert_done_pulse_R8: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);

  assert_err_with_done_R7: assert property (@(posedge clk) disable iff (!rst_n)
    error |-> done);

  assert_tmo_ones_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (reg_wr_en && reg_addr == A_TMO) |-> (&reg_wdata));

  assert_upper_kept_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (reg_wr_en && reg_addr == A_CLKSEL && have_up_q) |-> (reg_wdata[REG_W-1:3] == up_q));

  assert_single_read_R1: assert property (@(posedge clk) disable iff (!rst_n)
    reg_rd_en |=> !reg_rd_en);

endmodule

bind phase_tune_seq phase_tune_chk #(
  .REG_W(REG_W), .ADDR_W(ADDR_W), .CLKSEL_ADDR(CLKSEL_ADDR), .TMO_ADDR(TMO_ADDR)
) u_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .done       (done),
  .error      (error),
  .reg_rd_en  (reg_rd_en),
  .reg_wr_en  (reg_wr_en),
  .reg_addr   (reg_addr),
  .reg_wdata  (reg_wdata),
  .rd_upper   (reg_rdata[REG_W-1:3]),
  .trial_req  (trial_req),
  .trial_done (trial_done)
);

// File: tb/tb_phase_tune_seq.sv
`timescale 1ns/1ps
module tb_phase_tune_seq;

  localparam int REG_W = 32;
  localparam int ADDR_W = 4;
  localparam logic [ADDR_W-1:0] A_CLKSEL = 4'd0;
  localparam logic [ADDR_W-1:0] A_TMO    = 4'd1;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic start = 1'b0;
  logic done, error, reg_rd_en, reg_wr_en, trial_req;
  logic [ADDR_W-1:0] reg_addr;
  logic [REG_W-1:0]  reg_wdata;
  logic [REG_W-1:0]  reg_rdata = '0;
  logic trial_done = 1'b0;
  logic trial_pass = 1'b0;

  always #10 clk = ~clk;

  phase_tune_seq #(.REG_W(REG_W), .ADDR_W(ADDR_W), .CLKSEL_ADDR(0), .TMO_ADDR(1)) dut (
    .clk(clk), .rst_n(rst_n), .start(start), .done(done), .error(error),
    .reg_rd_en(reg_rd_en), .reg_wr_en(reg_wr_en), .reg_addr(reg_addr),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
    .trial_req(trial_req), .trial_done(trial_done), .trial_pass(trial_pass)
  );

  int n_checks = 0;
  int n_fail = 0;

  // environment and run state
  logic [REG_W-1:0] clksel_m = '0;
  logic [REG_W-1:0] tmo_m = '0;
  bit   tmo_fresh = 0;
  logic [7:0] pass_pat = '0;
  logic [REG_W-4:0] orig_up = '0;
  int start_ph = 0;
  int lat = 1;
  int trials = 0;
  int cs_writes = 0;
  int reads = 0;
  bit pending = 0;
  int cnt = 0;
  int cur_trial_ph = 0;
  bit sweep_over = 0;
  bit finished = 0;
  int c = 0;
  int exp_c = 0;
  bit exp_err = 0;

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    n_checks++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0d expected=%0d at %0t", tag, act, exp, $time);
    end
  endtask

  // Reference choice: phase-window rules stated in the requirements
  function automatic int pick_phase(input logic [7:0] m, output int steps);
    for (int t = 0; t < 3; t++) begin
      int lo, hi;
      lo = (t == 0) ? -1 : (t == 1) ? 0 : 1;
      hi = (t == 0) ?  3 : (t == 1) ? 2 : 1;
      for (int i = 0; i < 8; i++) begin
        bit ok;
        ok = 1;
        for (int d = lo; d <= hi; d++) if (!m[(i + d + 8) % 8]) ok = 0;
        if (ok) begin
          steps = t * 8 + i + 1;
          return i;
        end
      end
    end
    steps = 24;
    return -1;
  endfunction

  // Register model, trial responder and per-clock done comparison
  always @(negedge clk) begin
    if (rst_n) begin
      trial_done = 1'b0;
      if (sweep_over) begin
        c++;
        chk(done == (c == exp_c), "R8 done timing", int'(done), int'(c == exp_c));
        if (c == exp_c) begin
          chk(error == exp_err, exp_err ? "R7 error flag" : "R8 error low", int'(error), int'(exp_err));
          sweep_over = 0;
          finished = 1;
        end
      end else if (done) begin
        chk(0, "R9 unexpected done", 1, 0);
      end
      if (reg_wr_en && reg_addr == A_CLKSEL) begin
        chk(reg_wdata[REG_W-1:3] == orig_up, "R2 upper bits", int'(reg_wdata[REG_W-1:3]), int'(orig_up));
        clksel_m = reg_wdata;
        cs_writes++;
      end
      if (reg_wr_en && reg_addr == A_TMO) begin
        tmo_m = reg_wdata;
        tmo_fresh = 1;
      end
      if (reg_rd_en) begin
        reads++;
        reg_rdata = clksel_m;
      end
      if (trial_req) begin
        int exp_ph;
        exp_ph = (start_ph + trials + 1) % 8;
        chk(!pending, "R10 outstanding request", int'(pending), 0);
        chk(int'(clksel_m[2:0]) == exp_ph, "R1 trial phase", int'(clksel_m[2:0]), exp_ph);
        chk(tmo_fresh && (&tmo_m), "R3 timeout refresh", int'(tmo_fresh), 1);
        cur_trial_ph = int'(clksel_m[2:0]);
        tmo_m = '0;
        tmo_fresh = 0;
        trials++;
        pending = 1;
        cnt = lat;
      end else if (pending) begin
        cnt--;
        if (cnt == 0) begin
          trial_done = 1'b1;
          trial_pass = pass_pat[cur_trial_ph];
          pending = 0;
          if (trials == 8) begin
            sweep_over = 1;
            c = 0;
          end
        end
      end
    end
  end

  task automatic run_case(input logic [7:0] pat, input int s, input logic [REG_W-4:0] up,
                          input int l, input bit poke_busy);
    int ph, steps;
    string tag;
    @(negedge clk);
    pass_pat = pat;
    start_ph = s;
    orig_up = up;
    clksel_m = {up, 3'(s)};
    lat = l;
    trials = 0;
    cs_writes = 0;
    reads = 0;
    finished = 0;
    ph = pick_phase(pat, steps);
    exp_err = (ph < 0);
    exp_c = exp_err ? 25 : steps + 2;
    start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    if (poke_busy) begin
      repeat (6) @(negedge clk);
      start = 1'b1;
      @(negedge clk);
      start = 1'b0;
    end
    while (!finished) @(negedge clk);
    if (exp_err) tag = "R7 final phase";
    else if (steps <= 8) tag = "R4 final phase";
    else if (steps <= 16) tag = "R5 final phase";
    else tag = "R6 final phase";
    chk(int'(clksel_m[2:0]) == (exp_err ? s : ph), tag, int'(clksel_m[2:0]), exp_err ? s : ph);
    chk(clksel_m[REG_W-1:3] == up, "R2 final upper", int'(clksel_m[REG_W-1:3]), int'(up));
    chk(cs_writes == (exp_err ? 8 : 9), "R7 write count", cs_writes, exp_err ? 8 : 9);
    chk(trials == 8, "R1 trial count", trials, 8);
    chk(reads == 1, poke_busy ? "R9 single read" : "R1 single read", reads, 1);
    repeat (5) @(negedge clk);
    chk(trials == 8 && !done, "R9 no activity after run", trials, 8);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    chk(!done && !error && !trial_req && !reg_rd_en && !reg_wr_en, "R8 reset idle",
        int'({done, error, trial_req, reg_rd_en, reg_wr_en}), 0);
    rst_n = 1'b1;
    repeat (2) @(negedge clk);
    run_case(8'b0011_1110, 0, 29'h14B8_6002, 1, 0);  // five-wide window
    run_case(8'b0000_1110, 5, 29'h0ABC_1234, 2, 1);  // three-wide, busy start
    run_case(8'b0100_0100, 7, 29'h1FFF_FFFF, 3, 0);  // single passes
    run_case(8'b0000_0000, 3, 29'h0123_4567, 1, 0);  // nothing passes
    run_case(8'b1111_1111, 6, 29'h0000_0000, 2, 0);  // all pass, wrap window
    run_case(8'b1000_0011, 2, 29'h1555_5555, 1, 0);  // three-wide across wrap
    run_case(8'b1110_1101, 4, 29'h0F0F_0F0F, 3, 0);  // mixed
    $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    n_checks++;
    n_fail++;
    $display("FAIL watchdog actual=timeout expected=finish");
    $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
    $finish;
  end

endmodule